// File: doc/BRIEF.md
# ASCII Hex Record Receiver and Dispatcher

This block sits behind a serial receiver and reads a stream of ASCII characters that carry hex records. A record opens with a colon. Hex digit pairs follow, each pair one byte: a byte count, a big-endian 16-bit address, a record type, up to the configured number of data bytes, and a checksum. A CR or LF closes the record. The block turns the pairs into bytes, keeps the data bytes in a small buffer and adds up a running 8-bit checksum. It does nothing with a record until the terminator has arrived.

Once a record is complete and its checksum is good, the block decodes it into one or more requests on a simple request/done handshake toward a flash controller. The request kinds are: program a byte, set the oscillator value, erase a code block, erase the boot vector and status byte, set a security bit, and write a configuration byte. Each record then produces exactly one reply character for the transmitter. A '.' means success, an 'X' means a framing or checksum error, and an 'R' means the command was refused or failed. Data programming is refused until an oscillator record has completed.

Top module: `hexrec_dispatch`

## Requirements
- R1: After reset, reply_valid and req_valid are low. In the idle state every character other than ':' (0x3A) is ignored, and a ':' starts a new record.
- R2: Inside a record, the characters 0-9, A-F and a-f are hex digits, and each pair forms one byte with the first digit as the high nibble. The bytes are taken in this order: count, address high, address low, type, count data bytes, checksum.
- R3: A record whose 8-bit sum of all bytes from the count through the checksum is not zero gets the reply 'X' and issues no request.
- R4: The record is dropped at once, with reply 'X' and no request, in three cases: a non-hex character before the checksum is complete, a count above MAX_DATA (default 16), or any character other than CR (0x0D) or LF (0x0A) after the checksum.
- R5: No request and no reply is issued before the terminating CR or LF has been received.
- R6: A type 0x00 record issues one request of kind 0 (program) per data byte. The address is the record address plus the byte offset, modulo 2^16, and the requests go out in ascending order. If all complete with flash_ok the reply is '.'. The first completion with flash_ok low ends the record with 'R', and no further request follows. A count of zero replies '.' with no request.
- R7: A type 0x00 record that arrives before any type 0x02 record has completed successfully is answered 'R' and issues no request.
- R8: Type 0x01 replies '.' with no request. Type 0x02 with at least one data byte issues kind 1 (oscillator) with req_data equal to the first data byte.
- R9: Type 0x03 uses data byte 0 as the subfunction and byte 1 as the selection. Subfunction 0x01 with selection 0x00, 0x20, 0x40, 0x80 or 0xC0 gives kind 2 (block erase, req_sel = selection). Subfunction 0x04 gives kind 3 (boot-vector erase). Subfunction 0x05 with selection 0..2 gives kind 4 (security bit, req_sel = selection). Subfunction 0x06 with selection 0..2 and a third byte gives kind 5 (configuration write, req_data = third byte). Any other combination, a short count or an unknown record type replies 'R' with no request.
- R10: req_valid stays high, with kind, address, selection and data stable, until a cycle with flash_done high. The reply is '.' if flash_ok was high in that cycle and 'R' otherwise.
- R11: Each record gives exactly one reply_valid pulse, one cycle wide. reply_char is one of '.' (0x2E), 'X' (0x58) or 'R' (0x52).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_char | input | 8 | Received ASCII character |
| reply_valid | output | 1 | One-cycle pulse carrying the record's reply |
| reply_char | output | 8 | Reply character: '.', 'X' or 'R' |
| req_valid | output | 1 | Flash request pending |
| req_kind | output | 3 | Request kind, encoded 0..5 as listed in R6, R8 and R9 |
| req_addr | output | 16 | Target address (record address plus offset) |
| req_sel | output | 8 | Selection code for erase, security and configuration requests |
| req_data | output | 8 | Byte to program or write |
| flash_done | input | 1 | Flash controller has finished the pending request |
| flash_ok | input | 1 | Result of the finished request, valid with flash_done |

## Verification
The assertions check the handshake and reply properties on every cycle. These are: the requests hold steady until done, the reply is a single pulse with one of three legal codes, no program request goes out without a prior oscillator record, no request starts outside the execution phase, and an oversize count aborts on the next edge. The decoding of each record, which depends on the contents of a whole character sequence, can only be shown by the bench's scenarios. Those scenarios cover the address sequence of a data record, the mapping of subfunction and selection codes to request kinds, refusals, checksum errors, a program failure in the middle of a record, and the hold-off until the terminator.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

  typedef enum logic [2:0] {
    K_PROG       = 3'd0,
    K_OSC        = 3'd1,
    K_ERASE_BLK  = 3'd2,
    K_ERASE_BOOT = 3'd3,
    K_SECURITY   = 3'd4,
    K_CFG        = 3'd5
  } req_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FIELDS,
    S_TAIL,
    S_EXEC,
    S_NEXT,
    S_REQ
  } rx_state_e;

  localparam logic [7:0] CH_OK    = 8'h2E;
  localparam logic [7:0] CH_BAD   = 8'h58;
  localparam logic [7:0] CH_REJ   = 8'h52;
  localparam logic [7:0] CH_COLON = 8'h3A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;

  // Result is {is_hex, nibble}.
  function automatic logic [4:0] hex_nib(input logic [7:0] c);
    if (c >= 8'h30 && c <= 8'h39)
      return {1'b1, c[3:0]};
    else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66))
      return {1'b1, c[3:0] + 4'd9};
    else
      return 5'd0;
  endfunction

  function automatic logic blk_code_ok(input logic [7:0] s);
    return (s == 8'h00) || (s == 8'h20) || (s == 8'h40) ||
           (s == 8'h80) || (s == 8'hC0);
  endfunction

  function automatic logic [7:0] sum8(input logic [7:0] a, input logic [7:0] b);
    return a + b;
  endfunction

endpackage

// File: rtl/hexrec_byte_pack.sv
module hexrec_byte_pack import hexrec_pkg::*; #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             nib_valid,
  input  logic [3:0]       nib,
  output logic             byte_done,
  output logic [7:0]       byte_val,
  output logic [IDX_W-1:0] byte_idx,
  output logic [7:0]       sum
);

  logic             have_hi_q;
  logic [3:0]       hi_q;
  logic [IDX_W-1:0] cnt_q;
  logic [7:0]       sum_q;

  assign byte_done = nib_valid & have_hi_q;
  assign byte_val  = {hi_q, nib};
  assign byte_idx  = cnt_q;
  assign sum       = sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_hi_q <= 1'b0;
      hi_q      <= '0;
      cnt_q     <= '0;
      sum_q     <= '0;
    end else if (clear) begin
      have_hi_q <= 1'b0;
      cnt_q     <= '0;
      sum_q     <= '0;
    end else if (nib_valid) begin
      if (!have_hi_q) begin
        hi_q      <= nib;
        have_hi_q <= 1'b1;
      end else begin
        have_hi_q <= 1'b0;
        cnt_q     <= cnt_q + 1'b1;
        sum_q     <= sum8(sum_q, byte_val);
      end
    end
  end

endmodule

// File: rtl/hexrec_data_buf.sv
module hexrec_data_buf #(
  parameter int DEPTH = 16,
  parameter int IW    = 4
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [IW-1:0]   rd_idx,
  output logic [7:0]      rd_data,
  output logic [2:0][7:0] head
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

  for (genvar i = 0; i < 3; i++) begin : g_head
    assign head[i] = mem[i];
  end

endmodule

// File: rtl/hexrec_dispatch.sv
module hexrec_dispatch import hexrec_pkg::*; #(
  parameter int MAX_DATA = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_char,
  output logic        reply_valid,
  output logic [7:0]  reply_char,
  output logic        req_valid,
  output logic [2:0]  req_kind,
  output logic [15:0] req_addr,
  output logic [7:0]  req_sel,
  output logic [7:0]  req_data,
  input  logic        flash_done,
  input  logic        flash_ok
);

  localparam int IDX_W = $clog2(MAX_DATA + 5);
  localparam int BIW   = (MAX_DATA > 1) ? $clog2(MAX_DATA) : 1;
  localparam logic [7:0] MAX_B = 8'(MAX_DATA);
  localparam logic [IDX_W-1:0] IDX_DATA0 = IDX_W'(4);

  rx_state_e        state_q;
  logic [7:0]       cnt_q, type_q, ptr_q;
  logic [15:0]      addr_q;
  logic             osc_seen_q;

  // character decode
  logic [4:0] hx;
  logic       hex_ok, is_colon, is_term;
  assign hx       = hex_nib(rx_char);
  assign hex_ok   = hx[4];
  assign is_colon = (rx_char == CH_COLON);
  assign is_term  = (rx_char == CH_CR) || (rx_char == CH_LF);

  // named events
  logic             start_rec, nib_valid, byte_done, abort_evt, rec_done, exec_busy;
  logic             is_data_byte, is_chk_byte;
  logic [7:0]       byte_val, sum;
  logic [IDX_W-1:0] byte_idx, chk_idx;

  assign start_rec = rx_valid && (state_q == S_IDLE) && is_colon;
  assign nib_valid = rx_valid && (state_q == S_FIELDS) && hex_ok;
  assign rec_done  = rx_valid && (state_q == S_TAIL) && is_term;
  assign exec_busy = (state_q == S_EXEC) || (state_q == S_NEXT) || (state_q == S_REQ);

  hexrec_byte_pack #(.IDX_W(IDX_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(start_rec),
    .nib_valid(nib_valid), .nib(hx[3:0]),
    .byte_done(byte_done), .byte_val(byte_val), .byte_idx(byte_idx), .sum(sum)
  );

  assign chk_idx      = IDX_W'(cnt_q) + IDX_DATA0;
  assign is_data_byte = byte_done && (byte_idx >= IDX_DATA0) && (byte_idx < chk_idx);
  assign is_chk_byte  = byte_done && (byte_idx == chk_idx);

  assign abort_evt = (rx_valid && (state_q == S_FIELDS) && !hex_ok) ||
                     (byte_done && (byte_idx == '0) && (byte_val > MAX_B)) ||
                     (rx_valid && (state_q == S_TAIL) && !is_term);

  logic [7:0]       rd_data;
  logic [2:0][7:0]  head;

  hexrec_data_buf #(.DEPTH(MAX_DATA), .IW(BIW)) u_buf (
    .clk(clk), .wr_en(is_data_byte),
    .wr_idx(BIW'(byte_idx - IDX_DATA0)), .wr_data(byte_val),
    .rd_idx(BIW'(ptr_q)), .rd_data(rd_data), .head(head)
  );

  // record decision, evaluated in S_EXEC
  logic       dec_start, dec_prog;
  logic [7:0] dec_code, dec_sel, dec_data;
  req_kind_e  dec_kind;

  always_comb begin
    dec_start = 1'b0;
    dec_prog  = 1'b0;
    dec_code  = CH_REJ;
    dec_kind  = K_PROG;
    dec_sel   = '0;
    dec_data  = '0;
    if (sum != 8'h00) begin
      dec_code = CH_BAD;
    end else begin
      case (type_q)
        8'h00: if (osc_seen_q) begin
                 if (cnt_q == 8'd0) dec_code = CH_OK;
                 else               dec_prog = 1'b1;
               end
        8'h01: dec_code = CH_OK;
        8'h02: if (cnt_q >= 8'd1) begin
                 dec_start = 1'b1; dec_kind = K_OSC; dec_data = head[0];
               end
        8'h03: if (cnt_q >= 8'd2) begin
                 dec_sel = head[1];
                 case (head[0])
                   8'h01: if (blk_code_ok(head[1])) begin
                            dec_start = 1'b1; dec_kind = K_ERASE_BLK;
                          end
                   8'h04: begin dec_start = 1'b1; dec_kind = K_ERASE_BOOT; end
                   8'h05: if (head[1] <= 8'd2) begin
                            dec_start = 1'b1; dec_kind = K_SECURITY;
                          end
                   8'h06: if (head[1] <= 8'd2 && cnt_q >= 8'd3) begin
                            dec_start = 1'b1; dec_kind = K_CFG; dec_data = head[2];
                          end
                   default: ;
                 endcase
               end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      type_q      <= '0;
      ptr_q       <= '0;
      addr_q      <= '0;
      osc_seen_q  <= 1'b0;
      reply_valid <= 1'b0;
      reply_char  <= '0;
      req_valid   <= 1'b0;
      req_kind    <= '0;
      req_addr    <= '0;
      req_sel     <= '0;
      req_data    <= '0;
    end else begin
      reply_valid <= 1'b0;
      case (state_q)
        S_IDLE: if (start_rec) begin
          state_q <= S_FIELDS;
          ptr_q   <= '0;
        end
        S_FIELDS: if (abort_evt) begin
          reply_valid <= 1'b1; reply_char <= CH_BAD; state_q <= S_IDLE;
        end else if (byte_done) begin
          if (byte_idx == IDX_W'(0)) cnt_q <= byte_val;
          if (byte_idx == IDX_W'(1)) addr_q[15:8] <= byte_val;
          if (byte_idx == IDX_W'(2)) addr_q[7:0] <= byte_val;
          if (byte_idx == IDX_W'(3)) type_q <= byte_val;
          if (is_chk_byte) state_q <= S_TAIL;
        end
        S_TAIL: if (rec_done) begin
          state_q <= S_EXEC;
        end else if (abort_evt) begin
          reply_valid <= 1'b1; reply_char <= CH_BAD; state_q <= S_IDLE;
        end
        S_EXEC: if (dec_prog) begin
          state_q <= S_NEXT;
        end else if (dec_start) begin
          req_valid <= 1'b1;
          req_kind  <= dec_kind;
          req_addr  <= addr_q;
          req_sel   <= dec_sel;
          req_data  <= dec_data;
          state_q   <= S_REQ;
        end else begin
          reply_valid <= 1'b1; reply_char <= dec_code; state_q <= S_IDLE;
        end
        S_NEXT: begin
          req_valid <= 1'b1;
          req_kind  <= K_PROG;
          req_addr  <= addr_q + {8'h00, ptr_q};
          req_sel   <= '0;
          req_data  <= rd_data;
          state_q   <= S_REQ;
        end
        S_REQ: if (flash_done) begin
          req_valid <= 1'b0;
          if (!flash_ok) begin
            reply_valid <= 1'b1; reply_char <= CH_REJ; state_q <= S_IDLE;
          end else if (req_kind == K_PROG && (ptr_q + 8'd1) < cnt_q) begin
            ptr_q   <= ptr_q + 8'd1;
            state_q <= S_NEXT;
          end else begin
            if (req_kind == K_OSC) osc_seen_q <= 1'b1;
            reply_valid <= 1'b1; reply_char <= CH_OK; state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hexrec_dispatch_chk.sv
module hexrec_dispatch_chk #(
  parameter int MAX_DATA = 16,
  parameter int IDX_W    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reply_valid,
  input logic [7:0]       reply_char,
  input logic             req_valid,
  input logic [2:0]       req_kind,
  input logic [15:0]      req_addr,
  input logic [7:0]       req_sel,
  input logic [7:0]       req_data,
  input logic             flash_done,
  input logic             osc_seen,
  input logic             exec_busy,
  input logic             byte_done,
  input logic [IDX_W-1:0] byte_idx,
  input logic [7:0]       byte_val
);

  // R11
  reply_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |=> !reply_valid);

  // R11
  reply_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> (reply_char == 8'h2E || reply_char == 8'h58 || reply_char == 8'h52));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !flash_done) |=> (req_valid && $stable(req_kind) && $stable(req_addr)
                                    && $stable(req_sel) && $stable(req_data)));

  // R10
  reply_vs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !reply_valid);

  // R7
  prog_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd0) |-> osc_seen);

  // R5
  req_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> exec_busy);

  // R4
  count_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && byte_idx == '0 && byte_val > 8'(MAX_DATA)) |=>
      (reply_valid && reply_char == 8'h58));

endmodule

bind hexrec_dispatch hexrec_dispatch_chk #(.MAX_DATA(MAX_DATA), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .reply_valid(reply_valid), .reply_char(reply_char),
  .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
  .req_sel(req_sel), .req_data(req_data), .flash_done(flash_done),
  .osc_seen(osc_seen_q), .exec_busy(exec_busy),
  .byte_done(byte_done), .byte_idx(byte_idx), .byte_val(byte_val)
);

// File: tb/sim_hexrec_dispatch.sv
module sim_hexrec_dispatch;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, rx_valid, flash_done, flash_ok;
  logic [7:0]  rx_char, reply_char, req_sel, req_data;
  logic        reply_valid, req_valid;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;

  hexrec_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .reply_valid(reply_valid), .reply_char(reply_char),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_sel(req_sel), .req_data(req_data),
    .flash_done(flash_done), .flash_ok(flash_ok)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, n_reply = 0, n_log = 0, fwait = 0;
  logic [7:0]  last_reply;
  logic [2:0]  log_kind [64];
  logic [15:0] log_addr [64];
  logic [7:0]  log_data [64];
  logic [7:0]  log_sel  [64];
  logic        fail_en = 1'b0;
  logic [15:0] fail_addr = '0;
  logic [7:0]  rb [24];
  int          rb_n;

  // reply monitor
  initial forever begin
    @(negedge clk);
    if (reply_valid) begin last_reply = reply_char; n_reply++; end
  end

  // flash model: completes each request two cycles after seeing it
  initial begin
    flash_done = 1'b0; flash_ok = 1'b0;
    forever begin
      @(negedge clk);
      if (flash_done) flash_done = 1'b0;
      else if (req_valid) begin
        fwait++;
        if (fwait == 2) begin
          fwait = 0;
          if (n_log < 64) begin
            log_kind[n_log] = req_kind; log_addr[n_log] = req_addr;
            log_data[n_log] = req_data; log_sel[n_log]  = req_sel;
          end
          n_log++;
          flash_ok   = !(fail_en && req_addr == fail_addr);
          flash_done = 1'b1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n, input bit lo);
    if (n < 4'd10) return 8'h30 + {4'd0, n};
    return (lo ? 8'h61 : 8'h41) + {4'd0, n} - 8'd10;
  endfunction

  task automatic send_ch(input logic [7:0] c);
    @(negedge clk); rx_valid = 1'b1; rx_char = c;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit lo);
    send_ch(hexc(b[7:4], lo));
    send_ch(hexc(b[3:0], lo));
  endtask

  task automatic hdr(input int n, input logic [15:0] a, input logic [7:0] t);
    rb[0] = 8'(n); rb[1] = a[15:8]; rb[2] = a[7:0]; rb[3] = t; rb_n = 4 + n;
  endtask

  task automatic send_rec(input bit bad, input bit lo, input bit term);
    logic [7:0] s = 8'h00;
    send_ch(8'h3A);
    for (int i = 0; i < rb_n; i++) begin send_byte(rb[i], lo); s = s + rb[i]; end
    send_byte((8'h00 - s) ^ {7'd0, bad}, lo);
    if (term) begin send_ch(8'h0D); send_ch(8'h0A); end
  endtask

  task automatic expect_reply(input string tag, input logic [7:0] exp,
                              input int r0, input int l0, input int nlog);
    for (int i = 0; i < 400 && n_reply == r0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(n_reply == r0 + 1, tag, "reply pulses", n_reply - r0, 1);
    chk(last_reply == exp, tag, "reply char", last_reply, exp);
    chk(n_log - l0 == nlog, tag, "requests", n_log - l0, nlog);
  endtask

  task automatic run_rec(input string tag, input logic [7:0] exp, input int nlog,
                         input bit bad, input bit lo);
    int r0 = n_reply, l0 = n_log;
    send_rec(bad, lo, 1'b1);
    expect_reply(tag, exp, r0, l0, nlog);
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    chk(reply_valid == 1'b0, "R1", "reply_valid after reset", reply_valid, 0);
    chk(req_valid == 1'b0, "R1", "req_valid after reset", req_valid, 0);
  endtask

  task automatic t_noise();
    int r0 = n_reply;
    send_ch("Z"); send_ch("5"); send_ch(8'h0D);
    repeat (20) @(negedge clk);
    chk(n_reply == r0, "R1", "noise reply", n_reply - r0, 0);
  endtask

  task automatic t_data_no_osc();
    hdr(2, 16'h0100, 8'h00); rb[4] = 8'h11; rb[5] = 8'h22;
    run_rec("R7", 8'h52, 0, 0, 0);
  endtask

  task automatic t_eof();
    hdr(0, 16'h0000, 8'h01);
    run_rec("R8", 8'h2E, 0, 0, 0);
  endtask

  task automatic t_osc();
    int l0 = n_log;
    hdr(1, 16'h0000, 8'h02); rb[4] = 8'h0B;
    run_rec("R8", 8'h2E, 1, 0, 0);
    chk(log_kind[l0] == 3'd1, "R8", "osc kind", log_kind[l0], 1);
    chk(log_data[l0] == 8'h0B, "R8", "osc data", log_data[l0], 8'h0B);
  endtask

  task automatic t_data_ok();
    int l0 = n_log;
    hdr(3, 16'h12FE, 8'h00); rb[4] = 8'hA5; rb[5] = 8'h5A; rb[6] = 8'h3C;
    run_rec("R6", 8'h2E, 3, 0, 1);   // lower-case digits also exercise R2
    for (int i = 0; i < 3; i++) begin
      chk(log_kind[l0+i] == 3'd0, "R6", "prog kind", log_kind[l0+i], 0);
      chk(log_addr[l0+i] == 16'h12FE + 16'(i), "R2", "prog addr",
          log_addr[l0+i], 16'h12FE + i);
      chk(log_data[l0+i] == rb[4+i], "R2", "prog data", log_data[l0+i], rb[4+i]);
    end
    hdr(0, 16'h4000, 8'h00);
    run_rec("R6", 8'h2E, 0, 0, 0);
  endtask

  task automatic t_prog_fail();
    int l0 = n_log;
    fail_en = 1'b1; fail_addr = 16'h2001;
    hdr(3, 16'h2000, 8'h00); rb[4] = 8'h01; rb[5] = 8'h02; rb[6] = 8'h03;
    run_rec("R6", 8'h52, 2, 0, 0);
    chk(log_addr[l0+1] == 16'h2001, "R6", "failing addr", log_addr[l0+1], 16'h2001);
    fail_en = 1'b0;
  endtask

  task automatic t_bad_sum();
    hdr(1, 16'h0000, 8'h02); rb[4] = 8'h0C;
    run_rec("R3", 8'h58, 0, 1, 0);
  endtask

  task automatic t_aborts();
    int r0 = n_reply, l0 = n_log;
    send_ch(8'h3A); send_byte(8'h11, 0);          // count 17
    expect_reply("R4", 8'h58, r0, l0, 0);
    r0 = n_reply;
    send_ch(8'h3A); send_ch("0"); send_ch("G");   // non-hex digit
    expect_reply("R4", 8'h58, r0, l0, 0);
    r0 = n_reply;
    hdr(0, 16'h0000, 8'h01);
    send_rec(0, 0, 0); send_ch("Q");               // junk after checksum
    expect_reply("R4", 8'h58, r0, l0, 0);
  endtask

  task automatic t_cmds();
    int l0;
    l0 = n_log; hdr(2, 16'h0000, 8'h03); rb[4] = 8'h01; rb[5] = 8'hC0;
    run_rec("R9", 8'h2E, 1, 0, 0);
    chk(log_kind[l0] == 3'd2 && log_sel[l0] == 8'hC0, "R9", "erase block",
        {log_kind[l0], log_sel[l0]}, {3'd2, 8'hC0});
    hdr(2, 16'h0000, 8'h03); rb[4] = 8'h01; rb[5] = 8'h10;
    run_rec("R9", 8'h52, 0, 0, 0);
    l0 = n_log; hdr(2, 16'h0000, 8'h03); rb[4] = 8'h04; rb[5] = 8'h00;
    run_rec("R9", 8'h2E, 1, 0, 0);
    chk(log_kind[l0] == 3'd3, "R9", "boot erase kind", log_kind[l0], 3);
    l0 = n_log; hdr(2, 16'h0000, 8'h03); rb[4] = 8'h05; rb[5] = 8'h02;
    run_rec("R9", 8'h2E, 1, 0, 0);
    chk(log_kind[l0] == 3'd4 && log_sel[l0] == 8'h02, "R9", "security",
        {log_kind[l0], log_sel[l0]}, {3'd4, 8'h02});
    hdr(2, 16'h0000, 8'h03); rb[4] = 8'h05; rb[5] = 8'h03;
    run_rec("R9", 8'h52, 0, 0, 0);
    l0 = n_log; hdr(3, 16'h0000, 8'h03); rb[4] = 8'h06; rb[5] = 8'h01; rb[6] = 8'hFC;
    run_rec("R9", 8'h2E, 1, 0, 0);
    chk(log_kind[l0] == 3'd5 && log_sel[l0] == 8'h01 && log_data[l0] == 8'hFC,
        "R9", "config write", {log_kind[l0], log_sel[l0], log_data[l0]},
        {3'd5, 8'h01, 8'hFC});
    hdr(2, 16'h0000, 8'h03); rb[4] = 8'h06; rb[5] = 8'h01;
    run_rec("R9", 8'h52, 0, 0, 0);
    hdr(0, 16'h0000, 8'h07);
    run_rec("R9", 8'h52, 0, 0, 0);
  endtask

  task automatic t_flash_fail();
    fail_en = 1'b1; fail_addr = 16'h3333;
    hdr(2, 16'h3333, 8'h03); rb[4] = 8'h04; rb[5] = 8'h00;
    run_rec("R10", 8'h52, 1, 0, 0);
    fail_en = 1'b0;
  endtask

  task automatic t_holdoff();
    int r0 = n_reply, l0 = n_log;
    hdr(2, 16'h0000, 8'h03); rb[4] = 8'h04; rb[5] = 8'h00;
    send_rec(0, 0, 0);
    repeat (30) @(negedge clk);
    chk(n_reply == r0, "R5", "reply before terminator", n_reply - r0, 0);
    chk(n_log == l0, "R5", "request before terminator", n_log - l0, 0);
    send_ch(8'h0A);
    expect_reply("R5", 8'h2E, r0, l0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_char = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_noise();
    t_data_no_osc();
    t_eof();
    t_osc();
    t_data_ok();
    t_prog_fail();
    t_bad_sum();
    t_aborts();
    t_cmds();
    t_flash_fail();
    t_holdoff();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule